// File: doc/BRIEF.md
# E1 CRC-4 Multiframe International-Bit Generator

This block sits beside the timeslot-0 generator of a 2.048 Mbit/s E1 transmitter. It watches the outgoing, fully multiplexed PCM bit stream, one bit per clock. Once per frame it produces the serial bit that the timeslot-0 generator places in the first (international) bit position of that frame. A frame-start pulse marks the first bit of every 256-bit frame. A frame-type input, driven from the timeslot-0 generator's status, says whether the frame now starting carries the frame alignment word.

There are two modes. With the mode enable low, the block only selects a user bit: one user bit for alignment frames and the other for the remaining frames. With the enable high, the block first aligns a 16-frame multiframe to the next alignment frame. It then runs a 4-bit CRC with generator x^4 + x + 1 over each half of the multiframe, which is 8 frames or 2048 bits. Into the international-bit positions it interleaves three things: the CRC remainder of the previous half, a six-bit multiframe marker carried in odd frames, and the two user bits in the last two odd frames.

Top module: `e1c4_crc_mf`

## Requirements
- R1: After reset, si_out is 0 and no multiframe is locked.
- R2: si_out changes only on a clock edge where frame_start is 1. The value chosen there, from the inputs sampled on that edge, holds for the rest of the frame, whatever fas_frame, usr_s and usr_n do in between.
- R3: With crc_en = 0, the bit chosen at a frame start is usr_s when fas_frame = 1 and usr_n when fas_frame = 0.
- R4: With crc_en = 1 and no lock yet, the output follows the R3 rule. The first frame start with fas_frame = 1 locks the block, and that frame becomes multiframe frame 0.
- R5: While locked, the multiframe index rises by one at every frame start and wraps from 15 to 0. Frames 0-7 form the first sub-multiframe and frames 8-15 the second. Even-numbered frames carry check bits.
- R6: The check word of a sub-multiframe is the remainder of M(x)·x^4 divided by x^4 + x + 1. M(x) is every stream bit from the first bit of the sub-multiframe's first frame up to the bit before the next sub-multiframe begins, first bit highest order. The first bit of each even-numbered frame counts as 0. C1 is the x^3 coefficient and C4 the x^0 coefficient.
- R7: Frames 0, 2, 4 and 6 of a sub-multiframe carry C1, C2, C3 and C4 of the sub-multiframe just before it.
- R8: In the first sub-multiframe after a lock, the check-bit frames carry 0.
- R9: Frames 1, 3, 5, 7, 9 and 11 carry 0, 0, 1, 0, 1, 1 in that order.
- R10: Frame 13 carries usr_s and frame 15 carries usr_n, both sampled at that frame's start.
- R11: While crc_en is 0, the lock and the multiframe position are cleared, and from the next frame start the output follows R3. Raising crc_en again locks anew under R4.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit clock, one PCM bit per rising edge |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| pcm_bit | input | 1 | Outgoing multiplexed PCM stream bit |
| frame_start | input | 1 | High during the first bit of every frame |
| fas_frame | input | 1 | 1 when the frame now starting carries the alignment word |
| crc_en | input | 1 | 1 selects CRC multiframe mode, 0 selects user-bit mode |
| usr_s | input | 1 | User bit for alignment frames, and frame 13 in CRC mode |
| usr_n | input | 1 | User bit for non-alignment frames, and frame 15 in CRC mode |
| si_out | output | 1 | International bit for the current frame |

## Verification
A wrong multiframe index shows at the next odd frame start as a marker bit out of place, or as a user bit where a marker belongs, so it is seen within two frames. A corrupted CRC register, or a C-bit position that is not masked, stays hidden until the next sub-multiframe boundary. It then appears in the check bits of frames 0, 2, 4 and 6 or 8, 10, 12 and 14, up to eight frames later. The bench therefore runs sub-multiframes of all-zero, all-one and random data, drives random values into the masked positions, and compares every frame's bit against a long-division model.

// File: rtl/e1c4_pkg.sv
package e1c4_pkg;

  // CRC definition: x^4 + x + 1, the x^4 term implied
  localparam int unsigned            CRC_W        = 4;
  localparam logic [CRC_W-1:0]       POLY_DEFAULT = 4'b0011;

  // Marker pattern carried in odd frames; MSB goes out first (frame 1)
  localparam int unsigned            MFAS_LEN     = 6;
  localparam logic [MFAS_LEN-1:0]    MFAS_DEFAULT = 6'b001011;

  // Odd frames hold the marker plus two user slots
  localparam int unsigned MF_FRAMES  = 2 * (MFAS_LEN + 2);
  localparam int unsigned SMF_FRAMES = MF_FRAMES / 2;
  localparam int unsigned IDX_W      = $clog2(MF_FRAMES);
  localparam int unsigned SMF_W      = $clog2(SMF_FRAMES);
  localparam int unsigned CSEL_W     = $clog2(CRC_W);

  typedef enum logic [1:0] {
    SEL_USER = 2'd0,
    SEL_CBIT = 2'd1,
    SEL_SLOT = 2'd2
  } si_src_e;

  // One serial step of the direct-form divider (computes M*x^W mod G)
  function automatic logic [CRC_W-1:0] crc_step(
    input logic [CRC_W-1:0] state,
    input logic             din,
    input logic [CRC_W-1:0] poly
  );
    logic fb;
    fb       = din ^ state[CRC_W-1];
    crc_step = {state[CRC_W-2:0], 1'b0} ^ (fb ? poly : '0);
  endfunction

endpackage

// File: rtl/e1c4_rst_sync.sv
module e1c4_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_q
);

  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '0;
    end else begin
      sync_q <= {sync_q[0], 1'b1};
    end
  end

  assign rst_q = sync_q[1];

endmodule

// File: rtl/e1c4_mf_ctrl.sv
module e1c4_mf_ctrl
  import e1c4_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             frame_start,
  input  logic             fas_frame,
  input  logic             crc_en,
  output logic             lock_nxt,
  output logic [IDX_W-1:0] idx_nxt,
  output logic             lock_cur,
  output logic [IDX_W-1:0] idx_cur,
  output logic             smf_start,
  output logic             cpos
);

  localparam logic [IDX_W-1:0] IDX_LAST = IDX_W'(MF_FRAMES - 1);

  logic             locked_q, locked_d;
  logic [IDX_W-1:0] idx_q, idx_d;
  logic             upd_en;

  // Next-state: lock on first alignment frame, then count frames
  always_comb begin
    locked_d = locked_q;
    idx_d    = idx_q;
    if (!crc_en) begin
      locked_d = 1'b0;
      idx_d    = '0;
    end else if (frame_start) begin
      if (locked_q) begin
        idx_d = (idx_q == IDX_LAST) ? '0 : idx_q + 1'b1;
      end else if (fas_frame) begin
        locked_d = 1'b1;
        idx_d    = '0;
      end
    end
  end

  assign upd_en = frame_start | ~crc_en;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      locked_q <= 1'b0;
      idx_q    <= '0;
    end else if (upd_en) begin
      locked_q <= locked_d;
      idx_q    <= idx_d;
    end
  end

  assign lock_nxt  = locked_d;
  assign idx_nxt   = idx_d;
  assign lock_cur  = locked_q;
  assign idx_cur   = idx_q;
  assign smf_start = frame_start & locked_d & (idx_d[SMF_W-1:0] == '0);
  assign cpos      = frame_start & ~idx_d[0];

endmodule

// File: rtl/e1c4_crc_acc.sv
module e1c4_crc_acc
  import e1c4_pkg::*;
#(
  parameter logic [CRC_W-1:0] GEN_POLY = POLY_DEFAULT
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             pcm_bit,
  input  logic             cpos,
  input  logic             lock_nxt,
  input  logic             smf_start,
  output logic [CRC_W-1:0] crc_word
);

  logic [CRC_W-1:0] lfsr_q, lfsr_d;
  logic [CRC_W-1:0] hold_q, hold_d;
  logic             eff_bit;
  logic             hold_en;

  // Check-bit positions enter the division as zero
  always_comb begin
    eff_bit = pcm_bit & ~cpos;
    if (!lock_nxt) begin
      lfsr_d = '0;
      hold_d = '0;
    end else if (smf_start) begin
      lfsr_d = crc_step('0, eff_bit, GEN_POLY);
      hold_d = lfsr_q;
    end else begin
      lfsr_d = crc_step(lfsr_q, eff_bit, GEN_POLY);
      hold_d = hold_q;
    end
  end

  assign hold_en = smf_start | ~lock_nxt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lfsr_q <= '0;
    end else begin
      lfsr_q <= lfsr_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hold_q <= '0;
    end else if (hold_en) begin
      hold_q <= hold_d;
    end
  end

  // Forward the fresh remainder so C1 leaves in the boundary frame itself
  assign crc_word = hold_d;

endmodule

// File: rtl/e1c4_si_sel.sv
module e1c4_si_sel
  import e1c4_pkg::*;
#(
  parameter logic [MFAS_LEN-1:0] MFAS_WORD = MFAS_DEFAULT
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             frame_start,
  input  logic             lock_nxt,
  input  logic [IDX_W-1:0] idx_nxt,
  input  logic             fas_frame,
  input  logic             usr_s,
  input  logic             usr_n,
  input  logic [CRC_W-1:0] crc_word,
  output logic             si_out
);

  localparam int unsigned ODD_SLOTS = MF_FRAMES / 2;

  logic [ODD_SLOTS-1:0] odd_bits;
  logic [CRC_W-1:0]     crc_rev;
  logic [CSEL_W-1:0]    cslot;
  si_src_e              src;
  logic                 si_q, si_d;

  // Odd-frame content: marker bits first, then the two user slots
  for (genvar g = 0; g < ODD_SLOTS; g++) begin : g_odd
    if (g < MFAS_LEN) begin : g_mark
      assign odd_bits[g] = MFAS_WORD[MFAS_LEN-1-g];
    end else if (g == MFAS_LEN) begin : g_us
      assign odd_bits[g] = usr_s;
    end else begin : g_un
      assign odd_bits[g] = usr_n;
    end
  end

  // C1 (high-order) goes out first
  for (genvar c = 0; c < CRC_W; c++) begin : g_crev
    assign crc_rev[c] = crc_word[CRC_W-1-c];
  end

  always_comb begin
    cslot = idx_nxt[SMF_W-1:1];
    if (!lock_nxt) begin
      src = SEL_USER;
    end else if (!idx_nxt[0]) begin
      src = SEL_CBIT;
    end else begin
      src = SEL_SLOT;
    end
    case (src)
      SEL_CBIT: si_d = crc_rev[cslot];
      SEL_SLOT: si_d = odd_bits[idx_nxt[IDX_W-1:1]];
      default:  si_d = fas_frame ? usr_s : usr_n;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      si_q <= 1'b0;
    end else if (frame_start) begin
      si_q <= si_d;
    end
  end

  assign si_out = si_q;

endmodule

// File: rtl/e1c4_crc_mf.sv
module e1c4_crc_mf
  import e1c4_pkg::*;
#(
  parameter logic [MFAS_LEN-1:0] MFAS_WORD = MFAS_DEFAULT,
  parameter logic [CRC_W-1:0]    GEN_POLY  = POLY_DEFAULT
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pcm_bit,
  input  logic frame_start,
  input  logic fas_frame,
  input  logic crc_en,
  input  logic usr_s,
  input  logic usr_n,
  output logic si_out
);

  logic             rst_q;
  logic             lock_nxt, lock_cur;
  logic [IDX_W-1:0] idx_nxt, idx_cur;
  logic             smf_start, cpos;
  logic [CRC_W-1:0] crc_word;

  e1c4_rst_sync u_rst (
    .clk   (clk),
    .rst_n (rst_n),
    .rst_q (rst_q)
  );

  e1c4_mf_ctrl u_ctrl (
    .clk         (clk),
    .rst_n       (rst_q),
    .frame_start (frame_start),
    .fas_frame   (fas_frame),
    .crc_en      (crc_en),
    .lock_nxt    (lock_nxt),
    .idx_nxt     (idx_nxt),
    .lock_cur    (lock_cur),
    .idx_cur     (idx_cur),
    .smf_start   (smf_start),
    .cpos        (cpos)
  );

  e1c4_crc_acc #(
    .GEN_POLY (GEN_POLY)
  ) u_crc (
    .clk       (clk),
    .rst_n     (rst_q),
    .pcm_bit   (pcm_bit),
    .cpos      (cpos),
    .lock_nxt  (lock_nxt),
    .smf_start (smf_start),
    .crc_word  (crc_word)
  );

  e1c4_si_sel #(
    .MFAS_WORD (MFAS_WORD)
  ) u_sel (
    .clk         (clk),
    .rst_n       (rst_q),
    .frame_start (frame_start),
    .lock_nxt    (lock_nxt),
    .idx_nxt     (idx_nxt),
    .fas_frame   (fas_frame),
    .usr_s       (usr_s),
    .usr_n       (usr_n),
    .crc_word    (crc_word),
    .si_out      (si_out)
  );

endmodule

// File: rtl/e1c4_crc_mf_chk.sv
module e1c4_crc_mf_chk
  import e1c4_pkg::*;
(
  input logic             clk,
  input logic             rst_n,
  input logic             frame_start,
  input logic             fas_frame,
  input logic             crc_en,
  input logic             usr_s,
  input logic             usr_n,
  input logic             si_out,
  input logic             lock_cur,
  input logic [IDX_W-1:0] idx_cur
);

  localparam logic [IDX_W-1:0] IDX_LAST = IDX_W'(MF_FRAMES - 1);
  localparam logic [IDX_W-1:0] IDX_ONE5 = IDX_W'(5);

  AST_SI_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !frame_start |=> $stable(si_out)); // R2

  AST_PLAIN_SEL: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_start && !crc_en) |=> (si_out == $past(fas_frame ? usr_s : usr_n))); // R3

  AST_LOCK_ON_FAS: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(lock_cur) |-> ($past(frame_start && fas_frame && crc_en) && idx_cur == '0)); // R4

  AST_IDX_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (lock_cur && crc_en && !frame_start) |=> $stable(idx_cur)); // R5

  AST_IDX_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    (lock_cur && crc_en && frame_start && idx_cur == IDX_LAST) |=> (idx_cur == '0)); // R5

  AST_MARK_FRAME5: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(frame_start) && lock_cur && idx_cur == IDX_ONE5) |-> si_out); // R9

  AST_DROP_UNLOCK: assert property (@(posedge clk) disable iff (!rst_n)
    !crc_en |=> !lock_cur); // R11

endmodule

bind e1c4_crc_mf e1c4_crc_mf_chk u_chk (
  .clk         (clk),
  .rst_n       (rst_q),
  .frame_start (frame_start),
  .fas_frame   (fas_frame),
  .crc_en      (crc_en),
  .usr_s       (usr_s),
  .usr_n       (usr_n),
  .si_out      (si_out),
  .lock_cur    (lock_cur),
  .idx_cur     (idx_cur)
);

// File: tb/e1c4_crc_mf_test.sv
module e1c4_crc_mf_test;

  logic clk;
  logic rst_n, pcm_bit, frame_start, fas_frame, crc_en, usr_s, usr_n;
  logic si_out;

  int   checks;
  int   errors;
  bit   done;

  // bench-side model state
  bit         m_locked;
  bit         m_first;
  int         m_idx;
  logic [3:0] m_rem;
  logic [3:0] m_cprev;
  bit         g_fas;
  bit         drop_tag;

  initial clk = 1'b0;
  always #5 clk = ~clk;

  e1c4_crc_mf uut (
    .clk         (clk),
    .rst_n       (rst_n),
    .pcm_bit     (pcm_bit),
    .frame_start (frame_start),
    .fas_frame   (fas_frame),
    .crc_en      (crc_en),
    .usr_s       (usr_s),
    .usr_n       (usr_n),
    .si_out      (si_out)
  );

  // long division by 1 0011, message shifted in one bit at a time
  function automatic logic [3:0] div_step(input logic [3:0] r, input logic b);
    logic [4:0] t;
    t = {r, b};
    if (t[4]) t = t ^ 5'b10011;
    return t[3:0];
  endfunction

  function automatic logic [3:0] div_final(input logic [3:0] r);
    logic [3:0] t;
    t = r;
    for (int i = 0; i < 4; i++) t = div_step(t, 1'b0);
    return t;
  endfunction

  task automatic check_bit(input string req, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%b expected=%b", req, act, exp);
    end
  endtask

  task automatic run_frame(input bit en, input bit s, input bit n, input int pat);
    bit          fas;
    logic        exp;
    string       tag;
    logic [5:0]  mark;
    mark  = 6'b001011;
    fas   = g_fas;
    g_fas = ~g_fas;
    if (!en) begin
      m_locked = 1'b0;
      m_idx    = 0;
    end else if (!m_locked) begin
      if (fas) begin
        m_locked = 1'b1;
        m_first  = 1'b1;
        m_idx    = 0;
        m_rem    = '0;
        m_cprev  = '0;
      end
    end else begin
      m_idx = (m_idx + 1) % 16;
      if (m_idx % 8 == 0) begin
        m_cprev = div_final(m_rem);
        m_rem   = '0;
        m_first = 1'b0;
      end
    end
    if (!m_locked) begin
      exp = fas ? s : n;
      if (!en) tag = drop_tag ? "R11 user select after disable" : "R3 user select";
      else     tag = "R4 unlocked before alignment frame";
    end else if (m_idx % 2 == 0) begin
      exp = m_cprev[3 - ((m_idx % 8) / 2)];
      tag = m_first ? "R8 zero check bits after lock" : "R6 R7 check bit";
    end else if (m_idx < 12) begin
      exp = mark[5 - (m_idx - 1) / 2];
      tag = "R5 R9 marker bit";
    end else begin
      exp = (m_idx == 13) ? s : n;
      tag = "R10 user bit in multiframe";
    end
    for (int b = 0; b < 256; b++) begin
      @(negedge clk);
      if (b == 1)   check_bit(tag, si_out, exp);
      if (b == 200) check_bit("R2 held through frame", si_out, exp);
      frame_start = (b == 0);
      crc_en      = en;
      fas_frame   = (b == 0) ? fas : ~fas;
      usr_s       = (b == 0) ? s : ~s;
      usr_n       = (b == 0) ? n : ~n;
      case (pat)
        0:       pcm_bit = 1'b0;
        1:       pcm_bit = 1'b1;
        default: pcm_bit = 1'($urandom);
      endcase
      if (b == 0 && (m_idx % 2 == 0)) pcm_bit = 1'($urandom);
      if (m_locked) m_rem = div_step(m_rem, (b == 0 && m_idx % 2 == 0) ? 1'b0 : pcm_bit);
    end
  endtask

  initial begin
    checks = 0; errors = 0; done = 1'b0;
    m_locked = 1'b0; m_first = 1'b0; m_idx = 0; m_rem = '0; m_cprev = '0;
    g_fas = 1'b0; drop_tag = 1'b0;
    rst_n = 1'b0; pcm_bit = 1'b0; frame_start = 1'b0; fas_frame = 1'b0;
    crc_en = 1'b0; usr_s = 1'b1; usr_n = 1'b1;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    check_bit("R1 output after reset", si_out, 1'b0);
    repeat (2) @(negedge clk);
    check_bit("R1 output idle after reset", si_out, 1'b0);

    // user-bit mode: sweep every frame type / user bit combination
    for (int f = 0; f < 8; f++) run_frame(1'b0, f[1], f[2], 2);

    // CRC mode: first frame is a non-alignment frame, then lock
    for (int c = 0; c < 55; c++) begin
      run_frame(1'b1, (c % 3 == 0), (c % 5 < 2), (c / 16) % 3);
    end

    // drop the mode mid multiframe
    drop_tag = 1'b1;
    for (int c = 0; c < 3; c++) run_frame(1'b0, c[0], ~c[0], 2);
    drop_tag = 1'b0;

    // re-enable and relock
    for (int c = 0; c < 36; c++) begin
      run_frame(1'b1, (c % 4 < 2), (c % 7 > 2), 2);
    end

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #2000000;
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog run did not finish actual=hung expected=done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule